// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block sequences the power states of a small embedded processor core. It watches a pulse that says a HALT instruction has completed, an active-low stop-clock request, a group of wake events (maskable interrupt, non-maskable interrupt, management interrupt, soft reset), an external snoop strobe and a flag that says the input clock is present. From these it steps between five states: running, halted with the core clock gated, stop-granted, clock-stopped, and a one-cycle snoop detour.

A HALT or stop-grant entry is preceded by a special bus cycle. The controller raises a one-cycle request with a cycle-type bit. It then waits for the bus unit's completion acknowledge before it changes state. The controller remembers whether stop-grant was entered from the halted state. When the stop request is released, it goes back to halted, issuing a fresh HALT cycle, or it goes straight back to running. After the input clock returns in the clock-stopped state, a short counter must see eight consecutive clock-present cycles before stop-grant is reported again. The block also drives the core clock enable, a cache-invalidate strobe during snoops, and an enable that makes the pin drivers keep their last levels in the stopped states.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (running), `req_o` is 0, `core_clk_en_o` is 1, and `inval_o` and `pin_hold_o` are 0. The state codes are: running 0, halted 1, stop-granted 2, clock-stopped 3, snoop 4.
- R2: In running, a `halt_i` pulse raises `req_o` for exactly one cycle with `cyc_type_o` = 0 (HALT). The state changes to halted, with `core_clk_en_o` = 0, only on the cycle after `cyc_done_i` is seen.
- R3: A low `stop_n_i` in running or halted raises a one-cycle `req_o` with `cyc_type_o` = 1 (stop grant). After `cyc_done_i`, the state becomes stop-granted. In running, the stop request wins over a simultaneous `halt_i`.
- R4: In halted, any set bit of `wake_i` returns the state to running on the next cycle.
- R5: When `stop_n_i` goes high in stop-granted and that state was entered from running, the state returns to running with no bus request. If it was entered from halted, a HALT request (`cyc_type_o` = 0) is issued, and after `cyc_done_i` the state becomes halted.
- R6: In stop-granted, a low `clk_present_i` moves the state to clock-stopped on the next cycle.
- R7: In clock-stopped, the state becomes stop-granted after 8 consecutive cycles with `clk_present_i` high. A cycle with it low restarts the count.
- R8: `snoop_i` in halted or stop-granted (with no request pending) enters snoop for exactly one cycle, with `core_clk_en_o` and `inval_o` high. The state then returns to the state it came from.
- R9: `pin_hold_o` is high in stop-granted, in clock-stopped, and in a snoop entered from stop-granted. It is low in every other state.
- R10: `cpu_reset_i` forces running on the next cycle from any state and cancels a pending request. It also clears the memory of a halted origin, so a later stop-grant release goes to running.
- R11: While a request awaits `cyc_done_i`, `halt_i`, `stop_n_i`, `wake_i` and `snoop_i` have no effect. The cycle type and the target state of the pending request are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_reset_i | input | 1 | Synchronous processor reset event |
| halt_i | input | 1 | HALT instruction completed (pulse) |
| stop_n_i | input | 1 | Stop-clock request, active low |
| wake_i | input | NUM_WAKE | Wake events that end the halted state |
| snoop_i | input | 1 | External snoop strobe |
| clk_present_i | input | 1 | Input clock is running |
| cyc_done_i | input | 1 | Special bus cycle completed |
| state_o | output | 3 | Current power state code |
| req_o | output | 1 | One-cycle special bus cycle request |
| cyc_type_o | output | 1 | Requested cycle: 0 HALT, 1 stop grant |
| core_clk_en_o | output | 1 | Core clock enable |
| inval_o | output | 1 | Cache invalidate strobe |
| pin_hold_o | output | 1 | Keep output pins at their last level |

## Verification
The state graph is walked along both stop-grant entry paths, running and halted, and then released. This separates a correct origin memory from one that always returns to the same place. Snoops are tried from both halted and stop-granted, which shows whether the return state and the pin hold follow the origin. The restart count is tried with an unbroken run of clock-present cycles and with a run broken by one absent cycle, which exposes an off-by-one error or a count that fails to restart. Simultaneous requests, events while a cycle is pending, and a processor reset inside stop-grant check the priorities and the clearing of the origin memory.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

    typedef enum logic [2:0] {
        PS_RUN     = 3'd0,
        PS_HALTED  = 3'd1,
        PS_GRANT   = 3'd2,
        PS_STOPPED = 3'd3,
        PS_SNOOP   = 3'd4
    } pstate_e;

    typedef enum logic {
        CYC_HALT  = 1'b0,
        CYC_GRANT = 1'b1
    } cyc_e;

endpackage

// File: rtl/pwr_restart_cnt.sv
// Counts consecutive clock-present cycles after the input clock restarts.
module pwr_restart_cnt #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    output logic done_o
);
    localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [W-1:0] LAST = W'(CYCLES - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i || !run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    assign done_o = run_i && !clr_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/pwr_cyc_issue.sv
// Issues a one-cycle special bus cycle request and tracks its completion.
module pwr_cyc_issue
    import pwr_state_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic start_i,
    input  cyc_e type_i,
    input  logic done_i,
    output logic req_o,
    output cyc_e type_o,
    output logic busy_o,
    output logic fin_o
);
    typedef struct packed {
        logic req;
        logic busy;
        cyc_e typ;
    } iss_t;

    iss_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        fin_o   = s_q.busy && done_i && !flush_i;
        if (flush_i) begin
            s_d.busy = 1'b0;
        end else if (start_i && !s_q.busy) begin
            s_d.req  = 1'b1;
            s_d.busy = 1'b1;
            s_d.typ  = type_i;
        end else if (fin_o) begin
            s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{req: 1'b0, busy: 1'b0, typ: CYC_HALT};
        end else begin
            s_q <= s_d;
        end
    end

    assign req_o  = s_q.req;
    assign type_o = s_q.typ;
    assign busy_o = s_q.busy;

endmodule

// File: rtl/pwr_state_ctrl.sv
// Power state sequencer: running, halted, stop-granted, clock-stopped, snoop.
module pwr_state_ctrl
    import pwr_state_pkg::*;
#(
    parameter int NUM_WAKE       = 4,
    parameter int RESTART_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpu_reset_i,
    input  logic                halt_i,
    input  logic                stop_n_i,
    input  logic [NUM_WAKE-1:0] wake_i,
    input  logic                snoop_i,
    input  logic                clk_present_i,
    input  logic                cyc_done_i,
    output logic [2:0]          state_o,
    output logic                req_o,
    output logic                cyc_type_o,
    output logic                core_clk_en_o,
    output logic                inval_o,
    output logic                pin_hold_o
);
    typedef struct packed {
        pstate_e st;
        pstate_e tgt;
        pstate_e ret;
        logic    from_halt;
    } fsm_t;

    fsm_t q, d;
    logic start, busy, fin, restart_done, wake_any;
    cyc_e start_type, cur_type;

    assign wake_any = |wake_i;

    pwr_cyc_issue i_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (cpu_reset_i),
        .start_i (start),
        .type_i  (start_type),
        .done_i  (cyc_done_i),
        .req_o   (req_o),
        .type_o  (cur_type),
        .busy_o  (busy),
        .fin_o   (fin)
    );

    pwr_restart_cnt #(
        .CYCLES (RESTART_CYCLES)
    ) i_restart (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cpu_reset_i),
        .run_i  ((q.st == PS_STOPPED) && clk_present_i),
        .done_o (restart_done)
    );

    always_comb begin
        d          = q;
        start      = 1'b0;
        start_type = CYC_HALT;
        if (cpu_reset_i) begin
            d.st        = PS_RUN;
            d.tgt       = PS_RUN;
            d.ret       = PS_RUN;
            d.from_halt = 1'b0;
        end else if (busy) begin
            if (fin) begin
                d.st = q.tgt;
            end
        end else begin
            unique case (q.st)
                PS_RUN: begin
                    if (!stop_n_i) begin
                        start       = 1'b1;
                        start_type  = CYC_GRANT;
                        d.tgt       = PS_GRANT;
                        d.from_halt = 1'b0;
                    end else if (halt_i) begin
                        start      = 1'b1;
                        start_type = CYC_HALT;
                        d.tgt      = PS_HALTED;
                    end
                end
                PS_HALTED: begin
                    if (wake_any) begin
                        d.st = PS_RUN;
                    end else if (!stop_n_i) begin
                        start       = 1'b1;
                        start_type  = CYC_GRANT;
                        d.tgt       = PS_GRANT;
                        d.from_halt = 1'b1;
                    end else if (snoop_i) begin
                        d.st  = PS_SNOOP;
                        d.ret = PS_HALTED;
                    end
                end
                PS_GRANT: begin
                    if (!clk_present_i) begin
                        d.st = PS_STOPPED;
                    end else if (snoop_i) begin
                        d.st  = PS_SNOOP;
                        d.ret = PS_GRANT;
                    end else if (stop_n_i) begin
                        if (q.from_halt) begin
                            start       = 1'b1;
                            start_type  = CYC_HALT;
                            d.tgt       = PS_HALTED;
                            d.from_halt = 1'b0;
                        end else begin
                            d.st = PS_RUN;
                        end
                    end
                end
                PS_STOPPED: begin
                    if (restart_done) begin
                        d.st = PS_GRANT;
                    end
                end
                PS_SNOOP: begin
                    d.st = q.ret;
                end
                default: begin
                    d.st = PS_RUN;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: PS_RUN, tgt: PS_RUN, ret: PS_RUN, from_halt: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign state_o       = q.st;
    assign cyc_type_o    = cur_type;
    assign core_clk_en_o = (q.st == PS_RUN) || (q.st == PS_SNOOP);
    assign inval_o       = (q.st == PS_SNOOP);
    assign pin_hold_o    = (q.st == PS_GRANT) || (q.st == PS_STOPPED) ||
                           ((q.st == PS_SNOOP) && (q.ret == PS_GRANT));

endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
    import pwr_state_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_reset_i,
    input logic       wake_any,
    input logic       clk_present_i,
    input logic       busy,
    input logic [2:0] state_o,
    input logic       req_o,
    input logic       core_clk_en_o,
    input logic       inval_o,
    input logic       pin_hold_o
);
    assert_req_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |=> !req_o);

    assert_halt_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_HALTED) |-> !core_clk_en_o);

    assert_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_HALTED) && wake_any && !cpu_reset_i && !busy
        |=> (state_o == PS_RUN));

    assert_clk_loss_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_GRANT) && !clk_present_i && !cpu_reset_i && !busy
        |=> (state_o == PS_STOPPED));

    assert_stopped_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_STOPPED) && !cpu_reset_i
        |=> (state_o == PS_STOPPED) || (state_o == PS_GRANT));

    assert_snoop_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_SNOOP) |=> (state_o != PS_SNOOP));

    assert_inval_powered_R8: assert property (@(posedge clk) disable iff (!rst_n)
        inval_o |-> core_clk_en_o);

    assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == PS_STOPPED) |-> pin_hold_o);

    assert_cpu_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_i |=> (state_o == PS_RUN) && !req_o);

endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_reset_i   (cpu_reset_i),
    .wake_any      (wake_any),
    .clk_present_i (clk_present_i),
    .busy          (busy),
    .state_o       (state_o),
    .req_o         (req_o),
    .core_clk_en_o (core_clk_en_o),
    .inval_o       (inval_o),
    .pin_hold_o    (pin_hold_o)
);

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
    // input field order: halt, stop_n, wake, snoop, clk_present, done
    localparam logic [5:0] IDL = 6'b010010;
    localparam logic [5:0] HLT = 6'b110010;
    localparam logic [5:0] STP = 6'b000010;
    localparam logic [5:0] STD = 6'b000011;
    localparam logic [5:0] DON = 6'b010011;
    localparam logic [5:0] WAK = 6'b011010;
    localparam logic [5:0] SNP = 6'b010110;
    localparam logic [5:0] SSN = 6'b000110;
    localparam logic [5:0] SNC = 6'b000000;
    localparam int NVEC = 32;
    // {inputs, state, req, clk_en, inval, hold}
    localparam logic [12:0] VEC [0:NVEC-1] = '{
        {IDL, 3'd0, 4'b0100}, {HLT, 3'd0, 4'b1100}, {IDL, 3'd0, 4'b0100},
        {DON, 3'd1, 4'b0000}, {IDL, 3'd1, 4'b0000}, {SNP, 3'd4, 4'b0110},
        {IDL, 3'd1, 4'b0000}, {WAK, 3'd0, 4'b0100}, {STP, 3'd0, 4'b1100},
        {STD, 3'd2, 4'b0001}, {STP, 3'd2, 4'b0001}, {IDL, 3'd0, 4'b0100},
        {HLT, 3'd0, 4'b1100}, {DON, 3'd1, 4'b0000}, {STP, 3'd1, 4'b1000},
        {STD, 3'd2, 4'b0001}, {SSN, 3'd4, 4'b0111}, {STP, 3'd2, 4'b0001},
        {SNC, 3'd3, 4'b0001}, {SNC, 3'd3, 4'b0001}, {STP, 3'd3, 4'b0001},
        {STP, 3'd3, 4'b0001}, {STP, 3'd3, 4'b0001}, {STP, 3'd3, 4'b0001},
        {STP, 3'd3, 4'b0001}, {STP, 3'd3, 4'b0001}, {STP, 3'd3, 4'b0001},
        {STP, 3'd2, 4'b0001}, {IDL, 3'd2, 4'b1001}, {DON, 3'd1, 4'b0000},
        {WAK, 3'd0, 4'b0100}, {WAK, 3'd0, 4'b0100}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_reset = 1'b0;
    logic halt = 1'b0, stop_n = 1'b1, snoop = 1'b0, clkp = 1'b1, done = 1'b0;
    logic [3:0] wake = 4'b0;
    logic [2:0] state;
    logic req, ctype, clken, inval, hold;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pwr_state_ctrl i_pwr_state_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_reset_i(cpu_reset), .halt_i(halt),
        .stop_n_i(stop_n), .wake_i(wake), .snoop_i(snoop),
        .clk_present_i(clkp), .cyc_done_i(done), .state_o(state),
        .req_o(req), .cyc_type_o(ctype), .core_clk_en_o(clken),
        .inval_o(inval), .pin_hold_o(hold)
    );

    task automatic step(input logic [5:0] v, input logic [3:0] w, input logic cr);
        @(negedge clk);
        halt = v[5]; stop_n = v[4]; snoop = v[2]; clkp = v[1]; done = v[0];
        wake = w | {3'b000, v[3]};
        cpu_reset = cr;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [6:0] exp);
        logic [6:0] act;
        act = {state, req, clken, inval, hold};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: state/req/clken/inval/hold act=%b exp=%b", tag, act, exp);
        end
    endtask

    task automatic chk_type(input string tag, input logic exp);
        checks++;
        if (ctype !== exp || req !== 1'b1) begin
            fails++;
            $display("FAIL %s: type/req act=%b%b exp=%b1", tag, ctype, req, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 reset state", {3'd0, 4'b0100});

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][12:7], 4'b0, 1'b0);
            chk($sformatf("R2-R9 table vector %0d", i), VEC[i][6:0]);
        end

        // R3: stop request wins over halt
        step(6'b100010, 4'b0, 1'b0);
        chk_type("R3 stop over halt", 1'b1);
        step(STD, 4'b0, 1'b0);
        chk("R3 enter stop-grant", {3'd2, 4'b0001});
        step(IDL, 4'b0, 1'b0);
        chk("R5 release from running origin", {3'd0, 4'b0100});

        // R2: HALT cycle type
        step(HLT, 4'b0, 1'b0);
        chk_type("R2 halt cycle type", 1'b0);
        step(DON, 4'b0, 1'b0);
        chk("R2 halted after done", {3'd1, 4'b0000});

        // R4: highest wake bit
        step(IDL, 4'b1000, 1'b0);
        chk("R4 wake bit 3", {3'd0, 4'b0100});

        // R11: inputs ignored while pending
        step(HLT, 4'b0, 1'b0);
        step(6'b001110, 4'b0, 1'b0);
        chk("R11 ignored while pending", {3'd0, 4'b0100});
        step(DON, 4'b0, 1'b0);
        chk("R11 pending target kept", {3'd1, 4'b0000});

        // R10: reset clears halted origin
        step(STP, 4'b0, 1'b0);
        step(STD, 4'b0, 1'b0);
        chk("R10 setup stop-grant", {3'd2, 4'b0001});
        step(STP, 4'b0, 1'b1);
        chk("R10 cpu reset to running", {3'd0, 4'b0100});
        step(STP, 4'b0, 1'b0);
        step(STD, 4'b0, 1'b0);
        step(IDL, 4'b0, 1'b0);
        chk("R10 origin cleared", {3'd0, 4'b0100});

        // R7: broken restart run
        step(HLT, 4'b0, 1'b0);
        step(DON, 4'b0, 1'b0);
        step(STP, 4'b0, 1'b0);
        step(STD, 4'b0, 1'b0);
        step(SNC, 4'b0, 1'b0);
        chk("R6 clock loss", {3'd3, 4'b0001});
        repeat (4) step(STP, 4'b0, 1'b0);
        step(SNC, 4'b0, 1'b0);
        repeat (7) step(STP, 4'b0, 1'b0);
        chk("R7 seven after gap", {3'd3, 4'b0001});
        step(STP, 4'b0, 1'b0);
        chk("R7 eighth after gap", {3'd2, 4'b0001});
        step(IDL, 4'b0, 1'b0);
        chk_type("R5 halt reissue type", 1'b0);
        step(DON, 4'b0, 1'b0);
        chk("R5 back to halted", {3'd1, 4'b0000});
        step(WAK, 4'b0, 1'b0);
        chk("R4 final wake", {3'd0, 4'b0100});

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule